// File: doc/BRIEF.md
# Way-Predicted Write-Through First-Level Cache

This block is a 4 KB, 4-way set-associative first-level cache with 16-byte lines and 64 sets. The set index and the byte offset come from the untranslated low bits of the virtual address. The tag comes from the physical page number delivered by the translation unit. The index therefore fits inside the 1 KB page offset, and the lookup can start before translation finishes. The CPU issues one byte read or byte write at a time. The cache sends a request to the next level only after its own lookup has failed. Stores are the exception: every store is forwarded to the next level, whether or not it hits.

Each set holds a predicted way, and the tag in that way is checked first. A read hit in that way answers one cycle after acceptance. A hit in another way costs one more cycle, and the predictor is then moved to that way. When a line must be replaced, the cache first takes the lowest-numbered invalid way. If every way is valid, it takes the least recently used way, which is tracked by a 4x4 bit matrix per set. A store that misses does not allocate a line.

The controller is a five-state machine:
- ST_IDLE accepts a request and moves to ST_PROBE.
- ST_PROBE takes one of three transitions:
  - a predicted-way hit goes back to ST_IDLE for a read, or on to ST_WRITE for a store;
  - a hit in any other way goes to ST_ALT;
  - a miss goes to ST_FILL for a read, or to ST_WRITE for a store.
- ST_ALT answers a read and returns to ST_IDLE, or moves on to ST_WRITE for a store.
- ST_FILL and ST_WRITE hold the next-level request until it is acknowledged, then return to ST_IDLE.

Top module: `l1_wp_cache`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, `cpu_resp_valid` and `mem_req_valid` are 0, and every line is invalid, so the first read of any address misses.
- R2: The set index is `cpu_vaddr_lo[9:4]` and the byte offset is `cpu_vaddr_lo[3:0]`. The tag is the 15-bit `cpu_ptag`. A line is identified by its (index, tag) pair, so the same tag under a different index is a different line.
- R3: A read that hits the set's predicted way gives `cpu_resp_valid` in the first cycle after acceptance and makes no next-level request.
- R4: A read hit in a way other than the predicted one responds in the second cycle after acceptance. Afterwards the predictor points to that way, so the next read of that line responds in the first cycle.
- R5: A read miss makes no next-level request in the first cycle after acceptance. In the second cycle it raises a next-level read (`mem_req_we`=0) with address {tag, index, 4'b0000}. The requested byte is returned in the cycle in which `mem_resp_valid` is seen, and later reads of that line hit.
- R6: A fill goes into the lowest-numbered invalid way of the set, and the filled way becomes the predicted way.
- R7: Touching way i sets row i of the set's matrix to ones and clears column i. With all ways valid, the victim is the way whose row is all zeros, which is the least recently touched way.
- R8: Every store raises a next-level write (`mem_req_we`=1) carrying the full physical byte address and the data. The store completes only in the cycle in which `mem_resp_valid` is seen: the third cycle after acceptance for a hit outside the predicted way, and the second cycle otherwise.
- R9: A store that hits updates the cached byte, so a later read returns the new value without a next-level request.
- R10: A store that misses does not allocate, so a following read of that address still misses.
- R11: `cpu_req_ready` is 0 from acceptance until the request has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Cache idle, request accepted this cycle if valid |
| cpu_req_we | input | 1 | 1 = byte store, 0 = byte load |
| cpu_vaddr_lo | input | 10 | Untranslated low virtual address bits: index [9:4], offset [3:0] |
| cpu_ptag | input | 15 | Physical tag from translation |
| cpu_wdata | input | 8 | Store data |
| cpu_resp_valid | output | 1 | Request complete; load data valid |
| cpu_rdata | output | 8 | Load data |
| mem_req_valid | output | 1 | Next-level request, held until acknowledged |
| mem_req_we | output | 1 | 1 = write-through store, 0 = line read |
| mem_req_addr | output | 25 | Physical byte address (line aligned for reads) |
| mem_req_wdata | output | 8 | Store data for the next level |
| mem_resp_valid | input | 1 | Next-level acknowledge / read data valid |
| mem_resp_line | input | 128 | Line returned by the next level |

## Verification
The bench builds the cache with its default parameters: 25-bit physical addresses, 16-byte lines, 64 sets and 4 ways. Random accesses draw their index mostly from three fixed sets (the first, the last and one in the middle), with a random index mixed in. Tags come from a pool of six values, more than the four ways a set can hold. Under this pressure, predicted-way hits, other-way hits, fills into invalid ways, matrix-chosen evictions and store misses all occur many times within a few hundred accesses. Each outcome is compared against a bench-side reference model that tracks recency with timestamps rather than a matrix.

// File: rtl/l1c_pkg.sv
package l1c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_ALT,
        ST_FILL,
        ST_WRITE
    } l1c_state_t;

endpackage

// File: rtl/l1c_lru_matrix.sv
module l1c_lru_matrix #(
    parameter int SETS = 64,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     touch_en,
    input  logic [$clog2(SETS)-1:0]  touch_set,
    input  logic [$clog2(WAYS)-1:0]  touch_way,
    input  logic [$clog2(SETS)-1:0]  rd_set,
    output logic [$clog2(WAYS)-1:0]  victim_way
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int MAT_W = WAYS * WAYS;

    logic [MAT_W-1:0] mat_q [SETS];
    logic [MAT_W-1:0] touch_next;
    logic [MAT_W-1:0] rd_mat;

    // Row touch_way to ones, then column touch_way to zeros.
    always_comb begin
        touch_next = mat_q[touch_set];
        for (int j = 0; j < WAYS; j++) begin
            touch_next[int'(touch_way) * WAYS + j] = 1'b1;
        end
        for (int r = 0; r < WAYS; r++) begin
            touch_next[r * WAYS + int'(touch_way)] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                mat_q[s] <= '0;
            end
        end else if (touch_en) begin
            mat_q[touch_set] <= touch_next;
        end
    end

    // Lowest-numbered way whose row is all zeros.
    always_comb begin
        rd_mat     = mat_q[rd_set];
        victim_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (rd_mat[w * WAYS +: WAYS] == '0) begin
                victim_way = WAY_W'(w);
            end
        end
    end

    // R7: the way just touched is never the next victim of that set
    a_r7_touched_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && touch_set == rd_set) |=>
            ($stable(rd_set) -> victim_way != $past(touch_way)));

    logic [IDX_W-1:0] unused_idx_chk;
    assign unused_idx_chk = rd_set;

endmodule

// File: rtl/l1c_way_pred.sv
module l1c_way_pred #(
    parameter int SETS = 64,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd_en,
    input  logic [$clog2(SETS)-1:0]  upd_set,
    input  logic [$clog2(WAYS)-1:0]  upd_way,
    input  logic [$clog2(SETS)-1:0]  rd_set,
    output logic [$clog2(WAYS)-1:0]  pred_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] pred_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                pred_q[s] <= '0;
            end
        end else if (upd_en) begin
            pred_q[upd_set] <= upd_way;
        end
    end

    assign pred_way = pred_q[rd_set];

endmodule

// File: rtl/l1_wp_cache.sv
module l1_wp_cache
    import l1c_pkg::*;
#(
    parameter int PA_W       = 25,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 64,
    parameter int WAYS       = 4
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             cpu_req_valid,
    output logic                                             cpu_req_ready,
    input  logic                                             cpu_req_we,
    input  logic [$clog2(SETS)+$clog2(LINE_BYTES)-1:0]       cpu_vaddr_lo,
    input  logic [PA_W-$clog2(SETS)-$clog2(LINE_BYTES)-1:0]  cpu_ptag,
    input  logic [7:0]                                       cpu_wdata,
    output logic                                             cpu_resp_valid,
    output logic [7:0]                                       cpu_rdata,
    output logic                                             mem_req_valid,
    output logic                                             mem_req_we,
    output logic [PA_W-1:0]                                  mem_req_addr,
    output logic [7:0]                                       mem_req_wdata,
    input  logic                                             mem_resp_valid,
    input  logic [LINE_BYTES*8-1:0]                          mem_resp_line
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = PA_W - IDX_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = LINE_BYTES * 8;

    l1c_state_t state_q, state_d;

    logic             req_we_q;
    logic [IDX_W-1:0] req_idx_q;
    logic [OFF_W-1:0] req_off_q;
    logic [TAG_W-1:0] req_tag_q;
    logic [7:0]       req_wdata_q;
    logic [WAY_W-1:0] sel_way_q;

    logic [WAYS-1:0]   valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] data_q  [SETS][WAYS];

    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] hit_way, pred_way, lru_way, fill_way;
    logic             pred_hit, any_hit, fill_done;
    logic             touch_en, pred_upd;
    logic [WAY_W-1:0] touch_way;

    // Tag compare, one comparator per way
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[req_idx_q][w] && (tag_q[req_idx_q][w] == req_tag_q);
    end

    always_comb begin
        hit_way  = '0;
        fill_way = lru_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])            hit_way  = WAY_W'(w);
            if (!valid_q[req_idx_q][w]) fill_way = WAY_W'(w);
        end
    end

    assign pred_hit  = hit_vec[pred_way];
    assign any_hit   = |hit_vec;
    assign fill_done = (state_q == ST_FILL) && mem_resp_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req_valid) state_d = ST_PROBE;
            ST_PROBE: begin
                if (pred_hit)      state_d = req_we_q ? ST_WRITE : ST_IDLE;
                else if (any_hit)  state_d = ST_ALT;
                else               state_d = req_we_q ? ST_WRITE : ST_FILL;
            end
            ST_ALT:   state_d = req_we_q ? ST_WRITE : ST_IDLE;
            ST_FILL:  if (mem_resp_valid) state_d = ST_IDLE;
            ST_WRITE: if (mem_resp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_req_ready  = 1'b0;
        cpu_resp_valid = 1'b0;
        cpu_rdata      = '0;
        mem_req_valid  = 1'b0;
        mem_req_we     = 1'b0;
        mem_req_addr   = {req_tag_q, req_idx_q, {OFF_W{1'b0}}};
        mem_req_wdata  = req_wdata_q;
        unique case (state_q)
            ST_IDLE:  cpu_req_ready = 1'b1;
            ST_PROBE: begin
                cpu_resp_valid = pred_hit && !req_we_q;
                cpu_rdata      = data_q[req_idx_q][pred_way][{req_off_q, 3'b000} +: 8];
            end
            ST_ALT: begin
                cpu_resp_valid = !req_we_q;
                cpu_rdata      = data_q[req_idx_q][sel_way_q][{req_off_q, 3'b000} +: 8];
            end
            ST_FILL: begin
                mem_req_valid  = 1'b1;
                cpu_resp_valid = mem_resp_valid;
                cpu_rdata      = mem_resp_line[{req_off_q, 3'b000} +: 8];
            end
            ST_WRITE: begin
                mem_req_valid  = 1'b1;
                mem_req_we     = 1'b1;
                mem_req_addr   = {req_tag_q, req_idx_q, req_off_q};
                cpu_resp_valid = mem_resp_valid;
            end
            default: ;
        endcase
    end

    // Request latch and selected way
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we_q    <= 1'b0;
            req_idx_q   <= '0;
            req_off_q   <= '0;
            req_tag_q   <= '0;
            req_wdata_q <= '0;
            sel_way_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && cpu_req_valid) begin
                req_we_q    <= cpu_req_we;
                req_idx_q   <= cpu_vaddr_lo[OFF_W +: IDX_W];
                req_off_q   <= cpu_vaddr_lo[OFF_W-1:0];
                req_tag_q   <= cpu_ptag;
                req_wdata_q <= cpu_wdata;
            end
            if (state_q == ST_PROBE) begin
                sel_way_q <= any_hit ? hit_way : fill_way;
            end
        end
    end

    // Valid bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (fill_done) begin
            valid_q[req_idx_q][sel_way_q] <= 1'b1;
        end
    end

    // Tag and data storage
    always_ff @(posedge clk) begin
        if (fill_done) begin
            tag_q[req_idx_q][sel_way_q]  <= req_tag_q;
            data_q[req_idx_q][sel_way_q] <= mem_resp_line;
        end else if (state_q == ST_PROBE && pred_hit && req_we_q) begin
            data_q[req_idx_q][pred_way][{req_off_q, 3'b000} +: 8] <= req_wdata_q;
        end else if (state_q == ST_ALT && req_we_q) begin
            data_q[req_idx_q][sel_way_q][{req_off_q, 3'b000} +: 8] <= req_wdata_q;
        end
    end

    assign touch_en  = (state_q == ST_PROBE && pred_hit) || (state_q == ST_ALT) || fill_done;
    assign touch_way = (state_q == ST_PROBE) ? pred_way : sel_way_q;
    assign pred_upd  = (state_q == ST_ALT) || fill_done;

    l1c_lru_matrix #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_set  (req_idx_q),
        .touch_way  (touch_way),
        .rd_set     (req_idx_q),
        .victim_way (lru_way)
    );

    l1c_way_pred #(.SETS(SETS), .WAYS(WAYS)) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (pred_upd),
        .upd_set  (req_idx_q),
        .upd_way  (sel_way_q),
        .rd_set   (req_idx_q),
        .pred_way (pred_way)
    );

    // R2: a line is present in at most one way of its set
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE) |-> $onehot0(hit_vec));

    // R4: after a non-predicted hit the predictor follows the hit way
    a_r4_pred_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALT) |=> (pred_way == $past(sel_way_q)));

    // R5: a next-level read starts only after a probe that missed
    a_r5_look_through: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_valid) && !mem_req_we) |->
            ($past(state_q) == ST_PROBE && $past(hit_vec) == '0));

    // R8: a store never completes without the next level acknowledging it
    a_r8_store_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_resp_valid && req_we_q) |-> (mem_resp_valid && mem_req_valid && mem_req_we));

    // R11: no new request is taken while one is completing
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |-> !cpu_req_ready);

endmodule

// File: tb/tb_l1_wp_cache.sv
`timescale 1ns/1ps
module tb_l1_wp_cache;
    localparam int NS = 64;
    localparam int NW = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req_valid = 1'b0;
    logic         cpu_req_ready;
    logic         cpu_req_we = 1'b0;
    logic [9:0]   cpu_vaddr_lo = '0;
    logic [14:0]  cpu_ptag = '0;
    logic [7:0]   cpu_wdata = '0;
    logic         cpu_resp_valid;
    logic [7:0]   cpu_rdata;
    logic         mem_req_valid;
    logic         mem_req_we;
    logic [24:0]  mem_req_addr;
    logic [7:0]   mem_req_wdata;
    logic         mem_resp_valid = 1'b0;
    logic [127:0] mem_resp_line = '0;

    always #4 clk = ~clk;

    l1_wp_cache dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_vaddr_lo(cpu_vaddr_lo), .cpu_ptag(cpu_ptag),
        .cpu_wdata(cpu_wdata), .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_line(mem_resp_line)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  reported = 0;

    logic [7:0]  wmem [int];
    bit          m_valid [NS][NW];
    logic [14:0] m_tag   [NS][NW];
    int          m_stamp [NS][NW];
    int          m_pred  [NS];
    int          stamp_ctr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [24:0] pa);
        if (wmem.exists(int'(pa))) return wmem[int'(pa)];
        return pa[7:0] ^ pa[17:10] ^ 8'h5A;
    endfunction

    function automatic logic [127:0] build_line(input logic [24:0] pa);
        logic [127:0] l;
        for (int b = 0; b < 16; b++) l[b*8 +: 8] = mem_byte({pa[24:4], 4'(b)});
        return l;
    endfunction

    task automatic access(input bit we, input int idx, input logic [14:0] tag,
                          input logic [3:0] off, input logic [7:0] wd, input string lreq);
        logic [24:0] pa;
        int hw, vw, exp_lat, lat;
        bit exp_rdreq, seen_rd, seen_wr, done;
        logic [7:0] exp_rd, got_rd, seen_wd;
        logic [24:0] seen_addr;
        string kreq;
        pa = {tag, 6'(idx), off};
        hw = -1;
        for (int w = 0; w < NW; w++) if (m_valid[idx][w] && m_tag[idx][w] == tag) hw = w;
        exp_rd = mem_byte(pa);
        exp_rdreq = 0;
        if (hw >= 0) begin
            exp_lat = (hw == m_pred[idx]) ? 1 : 2;
            if (we) exp_lat++;
            kreq = we ? "R8" : ((hw == m_pred[idx]) ? "R3" : "R4");
            m_pred[idx] = hw;
            m_stamp[idx][hw] = ++stamp_ctr;
        end else if (we) begin
            exp_lat = 2;
            kreq = "R10";
        end else begin
            exp_lat = 2;
            exp_rdreq = 1;
            kreq = "R5";
            vw = -1;
            for (int w = NW - 1; w >= 0; w--) if (!m_valid[idx][w]) vw = w;
            if (vw < 0) begin
                vw = 0;
                for (int w = 1; w < NW; w++) if (m_stamp[idx][w] < m_stamp[idx][vw]) vw = w;
            end
            m_valid[idx][vw] = 1;
            m_tag[idx][vw] = tag;
            m_pred[idx] = vw;
            m_stamp[idx][vw] = ++stamp_ctr;
        end
        if (lreq != "") kreq = lreq;

        @(negedge clk);
        cpu_req_valid = 1; cpu_req_we = we; cpu_ptag = tag;
        cpu_vaddr_lo = {6'(idx), off}; cpu_wdata = wd;
        @(posedge clk);
        lat = 0; done = 0; seen_rd = 0; seen_wr = 0; got_rd = '0;
        seen_addr = '0; seen_wd = '0;
        while (!done && lat < 20) begin
            @(negedge clk);
            cpu_req_valid = 0;
            mem_resp_valid = 0;
            lat++;
            if (lat == 1) check(cpu_req_ready == 0, "R11", "ready while busy", cpu_req_ready, 0);
            if (mem_req_valid) begin
                seen_addr = mem_req_addr;
                if (mem_req_we) begin
                    seen_wr = 1; seen_wd = mem_req_wdata;
                    wmem[int'(mem_req_addr)] = mem_req_wdata;
                end else begin
                    seen_rd = 1;
                    mem_resp_line = build_line(mem_req_addr);
                end
                mem_resp_valid = 1;
            end
            #1;
            if (cpu_resp_valid) begin done = 1; got_rd = cpu_rdata; end
        end
        @(negedge clk);
        mem_resp_valid = 0;

        check(done && lat == exp_lat, kreq, "latency", lat, exp_lat);
        check(seen_rd == exp_rdreq, exp_rdreq ? "R5" : "R10", "next-level read", seen_rd, exp_rdreq);
        if (exp_rdreq && seen_rd)
            check(seen_addr == {pa[24:4], 4'b0}, "R5", "line address", seen_addr, {pa[24:4], 4'b0});
        check(seen_wr == we, "R8", "write-through issued", seen_wr, we);
        if (we && seen_wr) begin
            check(seen_addr == pa, "R8", "write address", seen_addr, pa);
            check(seen_wd == wd, "R8", "write data", seen_wd, wd);
        end
        if (!we) check(got_rd == exp_rd, (hw >= 0) ? "R9" : "R2", "read data", got_rd, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int unsigned seed;
        int sets_pick [3];
        sets_pick = '{0, 21, 63};
        seed = $urandom(32'd2024);
        for (int s = 0; s < NS; s++) begin
            m_pred[s] = 0;
            for (int w = 0; w < NW; w++) begin m_valid[s][w] = 0; m_stamp[s][w] = 0; m_tag[s][w] = '0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check(cpu_req_ready == 1, "R1", "ready after reset", cpu_req_ready, 1);
        check(cpu_resp_valid == 0, "R1", "resp after reset", cpu_resp_valid, 0);
        check(mem_req_valid == 0, "R1", "mem req after reset", mem_req_valid, 0);

        access(0, 5, 15'h0101, 4'h3, 8'h00, "R1");   // cold miss
        access(0, 5, 15'h0101, 4'h9, 8'h00, "R3");   // predicted hit
        access(0, 5, 15'h0102, 4'h0, 8'h00, "R6");   // fills way 1
        access(0, 5, 15'h0103, 4'h1, 8'h00, "R6");   // way 2
        access(0, 5, 15'h0104, 4'h2, 8'h00, "R6");   // way 3
        access(0, 5, 15'h0101, 4'h4, 8'h00, "R4");   // way 0, not predicted
        access(0, 5, 15'h0101, 4'h5, 8'h00, "R4");   // now predicted: 1 cycle
        access(0, 5, 15'h0105, 4'h6, 8'h00, "R7");   // evicts tag 0102
        access(0, 5, 15'h0102, 4'h6, 8'h00, "R7");   // must miss again
        access(0, 5, 15'h0101, 4'h6, 8'h00, "R7");   // survived
        access(1, 5, 15'h0101, 4'h7, 8'hAB, "R8");   // store hit
        access(0, 5, 15'h0101, 4'h7, 8'h00, "R9");   // reads back AB
        access(1, 9, 15'h0207, 4'h2, 8'hC4, "R10");  // store miss
        access(0, 9, 15'h0207, 4'h2, 8'h00, "R10");  // still a miss
        access(0, 6, 15'h0101, 4'h7, 8'h00, "R2");   // other index: distinct line

        for (int i = 0; i < 800; i++) begin
            int idx;
            logic [14:0] tg;
            idx = ($urandom % 4 == 3) ? int'($urandom % NS) : sets_pick[$urandom % 3];
            tg  = 15'h0300 + 15'($urandom % 6);
            access(($urandom % 4) == 0, idx, tg, 4'($urandom), 8'($urandom), "");
        end

        report();
        $finish;
    end
endmodule